// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This purely combinational unit sits between a 32-bit core and a data memory that is byte-addressed and one word wide. For a store, it takes the effective address, the access size and the register value. It produces two things: a per-lane write-enable mask, and write data with the operand copied onto every lane that the addressed bytes could occupy. For a load, it takes the word that memory returned, picks out the addressed byte or halfword, and widens it to 32 bits. The upper bits are filled with copies of the value's top bit for signed loads, and with zeros for unsigned loads.

The memory is little-endian: lane k (bits 8k+7:8k) holds the byte whose address ends in offset k. A halfword must start on an even address. A word must start on an address whose two low bits are zero. Bytes may sit anywhere. An access that breaks these rules raises a misalignment flag, enables no lanes and returns a zero load value. The core can then trap on the flag without any memory state being disturbed. The upper address bits pass straight through as the memory word address.

Top module: `ls_lane_align`

## Requirements
- R1: `mem_word_addr` equals `addr` shifted right by two (the address bits above the lane offset).
- R2: A byte access (`acc_size` = 2'b00) never sets `misalign`; an enabled byte store drives exactly lane `addr[1:0]`, i.e. `byte_en` = 4'b0001 << `addr[1:0]`.
- R3: A halfword access (`acc_size` = 2'b01) is misaligned when `addr[0]` = 1; an aligned halfword store enables 4'b0011 at offset 0 and 4'b1100 at offset 2.
- R4: A word access (`acc_size` = 2'b10) is misaligned unless `addr[1:0]` = 2'b00; an aligned word store enables 4'b1111.
- R5: `misalign` is high only while `req_valid` is high; when it is high, `byte_en` is 4'b0000 and `ld_data` is zero.
- R6: `byte_en` is 4'b0000 whenever `req_valid` is low or `req_write` is low (loads and idle cycles).
- R7: `mem_wdata` is the low byte of `st_data` copied to all four lanes for bytes, the low halfword copied to both halves for halfwords, and `st_data` unchanged for words.
- R8: A valid aligned byte load returns lane `addr[1:0]` of `mem_rdata` in bits 7:0, with bits 31:8 copied from bit 7 when `ld_unsigned` = 0 and zero when `ld_unsigned` = 1.
- R9: A valid aligned halfword load returns bytes `addr[1:0]` and `addr[1:0]`+1 of `mem_rdata` as bits 15:0, with bits 31:16 sign-filled or zero-filled by `ld_unsigned` as in R8.
- R10: A valid aligned word load returns `mem_rdata` unchanged, whatever `ld_unsigned` is.
- R11: `acc_size` = 2'b11 behaves exactly as a word access.
- R12: `ld_data` is zero whenever the request is not a valid load (`req_valid` low or `req_write` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| ld_unsigned | input | 1 | Zero-fill load result instead of sign-fill |
| addr | input | 32 | Effective byte address |
| st_data | input | 32 | Store operand, right-justified |
| mem_rdata | input | 32 | Word returned by memory |
| mem_word_addr | output | 30 | Word address to memory |
| byte_en | output | 4 | Per-lane write enable, lane k = byte offset k |
| mem_wdata | output | 32 | Lane-replicated write data |
| ld_data | output | 32 | Extracted and extended load result |
| misalign | output | 1 | Access violates its size alignment |

## Verification
The bound checker evaluates the lane mask on every input change. It confirms that enables appear only for valid aligned stores, that a misaligned access never drives a lane or a load value, that byte accesses never flag misalignment, that an aligned store enables exactly as many lanes as its size and includes the addressed lane, and that an idle or store request returns a zero load value. What only the bench scenarios can show is the data itself: which lane each byte lands on or is taken from, the sign or zero fill chosen by `ld_unsigned`, the replication pattern of the write data, and the treatment of the spare size code. The bench compares these against its own per-size model over random and directed addresses.

// File: rtl/ls_lane_pkg.sv
package ls_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // number of bytes touched by an access of the given size
  function automatic int size_bytes(acc_size_e s, int lanes);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return lanes;
    endcase
  endfunction

  // spare code folds onto the full-width access
  function automatic acc_size_e norm_size(logic [1:0] raw);
    return (raw == 2'b11) ? SZ_WORD : acc_size_e'(raw);
  endfunction

endpackage

// File: rtl/ls_lane_mask.sv
module ls_lane_mask
  import ls_lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = $clog2(LANES)
) (
  input  acc_size_e          size_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [LANES-1:0]   mask_o,
  output logic               aligned_o
);

  always_comb begin
    int n;
    int o;
    n = size_bytes(size_i, LANES);
    o = int'(ofs_i);
    aligned_o = ((o & (n - 1)) == 0);
    for (int k = 0; k < LANES; k++) begin
      mask_o[k] = (k >= o) && (k < o + n);
    end
  end

endmodule

// File: rtl/ls_store_steer.sv
module ls_store_steer
  import ls_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES
) (
  input  acc_size_e        size_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o
);

  always_comb begin
    int n;
    n = size_bytes(size_i, LANES);
    for (int k = 0; k < LANES; k++) begin
      data_o[8*k +: 8] = data_i[8*(k % n) +: 8];
    end
  end

endmodule

// File: rtl/ls_load_extend.sv
module ls_load_extend
  import ls_lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = $clog2(LANES),
  localparam int DW   = 8 * LANES
) (
  input  acc_size_e         size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              unsigned_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o
);

  logic [DW-1:0] shifted;
  logic          fill_b;
  logic          fill_h;

  always_comb begin
    shifted = data_i >> {ofs_i, 3'b000};
    fill_b  = shifted[7]  & ~unsigned_i;
    fill_h  = shifted[15] & ~unsigned_i;
    case (size_i)
      SZ_BYTE: data_o = {{(DW-8){fill_b}},  shifted[7:0]};
      SZ_HALF: data_o = {{(DW-16){fill_h}}, shifted[15:0]};
      default: data_o = data_i;
    endcase
  end

endmodule

// File: rtl/ls_lane_align.sv
module ls_lane_align
  import ls_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              acc_size,
  input  logic                    ld_unsigned,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [ADDR_W-OFS_W-1:0] mem_word_addr,
  output logic [LANES-1:0]        byte_en,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [DATA_W-1:0]       ld_data,
  output logic                    misalign
);

  // named internal events for the checker
  acc_size_e          size_code;
  logic [OFS_W-1:0]   ofs;
  logic [LANES-1:0]   lane_mask;
  logic               addr_aligned;
  logic               store_go;
  logic               load_go;
  logic [DATA_W-1:0]  ext_data;

  assign size_code     = norm_size(acc_size);
  assign ofs           = addr[OFS_W-1:0];
  assign mem_word_addr = addr[ADDR_W-1:OFS_W];

  ls_lane_mask #(.LANES(LANES), .OFS_W(OFS_W)) u_mask (
    .size_i    (size_code),
    .ofs_i     (ofs),
    .mask_o    (lane_mask),
    .aligned_o (addr_aligned)
  );

  ls_store_steer #(.LANES(LANES)) u_steer (
    .size_i (size_code),
    .data_i (st_data),
    .data_o (mem_wdata)
  );

  ls_load_extend #(.LANES(LANES), .OFS_W(OFS_W)) u_ext (
    .size_i     (size_code),
    .ofs_i      (ofs),
    .unsigned_i (ld_unsigned),
    .data_i     (mem_rdata),
    .data_o     (ext_data)
  );

  assign misalign = req_valid & ~addr_aligned;
  assign store_go = req_valid &  req_write & addr_aligned;
  assign load_go  = req_valid & ~req_write & addr_aligned;
  assign byte_en  = store_go ? lane_mask : '0;
  assign ld_data  = load_go  ? ext_data  : '0;

endmodule

// File: rtl/ls_lane_align_chk.sv
module ls_lane_align_chk
  import ls_lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 32
) (
  input logic              req_valid,
  input logic              req_write,
  input acc_size_e         size_code,
  input logic [OFS_W-1:0]  ofs,
  input logic [LANES-1:0]  byte_en,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);

  always_comb begin
    // R5
    misalign_needs_valid_chk: assert (!misalign || req_valid)
      else $error("misalign without request");
    // R5
    no_lane_on_misalign_chk: assert (!misalign || byte_en == '0)
      else $error("lanes driven on misaligned access");
    // R5
    no_load_on_misalign_chk: assert (!misalign || ld_data == '0)
      else $error("load value on misaligned access");
    // R6
    no_lane_unless_store_chk: assert ((req_valid && req_write) || byte_en == '0)
      else $error("lanes driven without a store");
    // R12
    no_load_unless_load_chk: assert ((req_valid && !req_write) || ld_data == '0)
      else $error("load value without a load");
    // R2
    byte_never_misaligned_chk: assert (!(misalign && size_code == SZ_BYTE))
      else $error("byte access flagged misaligned");
    // R3
    lane_count_matches_size_chk: assert (byte_en == '0 ||
        $countones(byte_en) == size_bytes(size_code, LANES))
      else $error("lane count does not match size");
    // R2
    addressed_lane_on_chk: assert (!(req_valid && req_write && !misalign) || byte_en[ofs])
      else $error("addressed lane not enabled");
  end

endmodule

bind ls_lane_align ls_lane_align_chk #(
  .LANES(LANES), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .req_valid (req_valid),
  .req_write (req_write),
  .size_code (size_code),
  .ofs       (ofs),
  .byte_en   (byte_en),
  .ld_data   (ld_data),
  .misalign  (misalign)
);

// File: tb/ls_lane_align_test.sv
module ls_lane_align_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        req_valid, req_write, ld_unsigned;
  logic [1:0]  acc_size;
  logic [31:0] addr, st_data, mem_rdata;
  logic [29:0] mem_word_addr;
  logic [3:0]  byte_en;
  logic [31:0] mem_wdata, ld_data;
  logic        misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ls_lane_align uut (
    .req_valid(req_valid), .req_write(req_write), .acc_size(acc_size),
    .ld_unsigned(ld_unsigned), .addr(addr), .st_data(st_data),
    .mem_rdata(mem_rdata), .mem_word_addr(mem_word_addr), .byte_en(byte_en),
    .mem_wdata(mem_wdata), .ld_data(ld_data), .misalign(misalign)
  );

  // ---------------- reference model ----------------
  function automatic int nbytes(logic [1:0] sz);
    if (sz == 2'b00) return 1;
    if (sz == 2'b01) return 2;
    return 4;
  endfunction

  function automatic bit m_mis(bit v, logic [1:0] sz, logic [1:0] o);
    if (!v) return 1'b0;
    case (nbytes(sz))
      1: return 1'b0;
      2: return o[0];
      default: return (o != 2'b00);
    endcase
  endfunction

  function automatic logic [3:0] m_be(bit v, bit w, logic [1:0] sz, logic [1:0] o);
    if (!v || !w || m_mis(v, sz, o)) return 4'b0000;
    case (nbytes(sz))
      1: return 4'b0001 << o;
      2: return o[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_wd(logic [1:0] sz, logic [31:0] d);
    case (nbytes(sz))
      1: return {4{d[7:0]}};
      2: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] m_ld(bit v, bit w, logic [1:0] sz, bit u,
                                       logic [1:0] o, logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    if (!v || w || m_mis(v, sz, o)) return 32'h0;
    b = r[8*o +: 8];
    h = o[1] ? r[31:16] : r[15:0];
    case (nbytes(sz))
      1: return u ? {24'h0, b} : {{24{b[7]}}, b};
      2: return u ? {16'h0, h} : {{16{h[15]}}, h};
      default: return r;
    endcase
  endfunction

  function automatic string size_tag_st(logic [1:0] sz);
    case (sz)
      2'b00: return "R2"; 2'b01: return "R3"; 2'b10: return "R4"; default: return "R11";
    endcase
  endfunction

  function automatic string size_tag_ld(logic [1:0] sz);
    case (sz)
      2'b00: return "R8"; 2'b01: return "R9"; 2'b10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (sz=%b addr=%h v=%b w=%b u=%b)",
               tag, what, act, exp, acc_size, addr, req_valid, req_write, ld_unsigned);
    end
  endtask

  task automatic run(bit v, bit w, logic [1:0] sz, bit u,
                     logic [31:0] a, logic [31:0] sd, logic [31:0] rd);
    bit mis;
    string tg;
    @(negedge clk);
    req_valid = v; req_write = w; acc_size = sz; ld_unsigned = u;
    addr = a; st_data = sd; mem_rdata = rd;
    #1;
    mis = m_mis(v, sz, a[1:0]);
    cmp("R1", "word_addr", {2'b00, mem_word_addr}, {2'b00, a[31:2]});
    tg = !v ? "R5" : size_tag_st(sz);
    cmp(tg, "misalign", {31'h0, misalign}, {31'h0, mis});
    tg = (!v || !w) ? "R6" : (mis ? "R5" : size_tag_st(sz));
    cmp(tg, "byte_en", {28'h0, byte_en}, {28'h0, m_be(v, w, sz, a[1:0])});
    cmp("R7", "wdata", mem_wdata, m_wd(sz, sd));
    tg = (!v || w) ? "R12" : (mis ? "R5" : size_tag_ld(sz));
    cmp(tg, "ld_data", ld_data, m_ld(v, w, sz, u, a[1:0], rd));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    req_valid = 0; req_write = 0; acc_size = 0; ld_unsigned = 0;
    addr = 0; st_data = 0; mem_rdata = 0;

    // idle state: no lanes, no load value, no flag (R6, R12, R5)
    run(0, 0, 2'b10, 0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(0, 1, 2'b01, 0, 32'h0000_0003, 32'h1234_5678, 32'h8765_4321);

    // R2: byte stores on each lane, never misaligned
    for (int o = 0; o < 4; o++)
      run(1, 1, 2'b00, 0, 32'h1000_0000 + o, 32'hCAFE_BEA5, 32'h0);
    // R3: halfword stores, aligned and misaligned
    for (int o = 0; o < 4; o++)
      run(1, 1, 2'b01, 0, 32'h2000_0010 + o, 32'h0000_F00D, 32'h0);
    // R4: word stores at all offsets
    for (int o = 0; o < 4; o++)
      run(1, 1, 2'b10, 0, 32'h3000_0100 + o, 32'hDEAD_BEEF, 32'h0);
    // R11: spare size code behaves as word
    run(1, 1, 2'b11, 0, 32'h0000_0040, 32'h0BAD_F00D, 32'h0);
    run(1, 0, 2'b11, 1, 32'h0000_0042, 32'h0, 32'h8000_0001);
    run(1, 0, 2'b11, 0, 32'h0000_0044, 32'h0, 32'h8000_0001);
    // R8: byte loads with negative and positive lanes, signed and unsigned
    for (int o = 0; o < 4; o++) begin
      run(1, 0, 2'b00, 0, 32'h0000_0200 + o, 32'h0, 32'h7F80_FF01);
      run(1, 0, 2'b00, 1, 32'h0000_0200 + o, 32'h0, 32'h7F80_FF01);
    end
    // R9: halfword loads, including misaligned (R5)
    for (int o = 0; o < 4; o++) begin
      run(1, 0, 2'b01, 0, 32'h0000_0300 + o, 32'h0, 32'h8001_7FFE);
      run(1, 0, 2'b01, 1, 32'h0000_0300 + o, 32'h0, 32'h8001_7FFE);
    end
    // R10: word load ignores the unsigned flag
    run(1, 0, 2'b10, 0, 32'hFFFF_FFFC, 32'h0, 32'hFEDC_BA98);
    run(1, 0, 2'b10, 1, 32'hFFFF_FFFC, 32'h0, 32'hFEDC_BA98);
    // R12: store returns no load value even with busy read bus
    run(1, 1, 2'b00, 0, 32'h0000_0001, 32'h55, 32'hFFFF_FFFF);

    // constrained random mix (R1..R12)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (($urandom % 4) == 0) a[1:0] = 2'b00;
      run(($urandom % 8) != 0, $urandom % 2, 2'($urandom), $urandom % 2,
          a, $urandom, $urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule